// File: doc/BRIEF.md
# Qualified Overlapping Serial Pattern Detector

This block watches a serial stream that arrives one bit per accepted cycle. It raises a single-cycle flag whenever the most recent eight accepted bits, oldest first, form 0,1,1,0,1,0,0,1. Occurrences may share bits. After a hit, any tail of the pattern that is also a head of it counts toward the next occurrence.

A mode input selects between two behaviours. In free mode every occurrence is flagged. In qualified mode the stream must open with two zero bits. If either of its first two accepted bits is 1, the detector locks out and stays silent for the rest of the stream. The mode is captured on reset and on each start pulse. A start pulse begins a new stream.

There are two state machines, and both advance only on accepted bits.

The progress machine has eight states, `M0` to `M7`. State `Mk` means that k leading pattern bits are matched.
- A matching bit moves the machine from `Mk` to `Mk+1`.
- A mismatching bit falls back along the longest proper suffix that is also a pattern prefix.
  - `M0`: on 1, stays in `M0`.
  - `M1` and `M2`: on 0, go to `M1`.
  - `M3`: on 1, goes to `M0`.
  - `M4`: on 0, goes to `M1`.
  - `M5`: on 1, goes to `M3`.
  - `M6`: on 1, goes to `M2`.
  - `M7`: on 0, goes to `M1`.
- `M7` on 1 is the hit transition, and it leads to `M2`.

The prefix machine has four states: `G_WAIT0` (no bit seen), `G_WAIT1` (one zero seen), `G_PASS` (qualified) and `G_LOCK` (rejected).
- From `G_WAIT0`, a 0 goes to `G_WAIT1` and a 1 goes to `G_LOCK`.
- From `G_WAIT1`, a 0 goes to `G_PASS` and a 1 goes to `G_LOCK`.
- `G_PASS` and `G_LOCK` hold until reset or start returns the machine to `G_WAIT0`.

Top module: `pw_detector`

## Requirements
- R1: In free mode, `hit` is 1 on an accepted cycle exactly when that bit together with the seven accepted bits before it, oldest first, equals 0,1,1,0,1,0,0,1. It is 0 on every other cycle.
- R2: Matches overlap. The accepted stream 01101001101001 gives hits on its 8th and 14th bits only.
- R3: `hit` never stays high for two consecutive cycles.
- R4: A cycle with `bit_vld` low leaves both machines unchanged, and `hit` is 0 in that cycle whatever `bit_in` carries.
- R5: In qualified mode, if the first or the second accepted bit after reset or start is 1, `hit` stays 0 until the next reset or start. For example, 1001101001 and 0101101001 give no hit.
- R6: In qualified mode, once the stream opens with 00, hits follow R1 and R2. The second zero may be the first pattern bit, so 001101001 hits on its 9th bit and 0001101001 hits on its 10th bit.
- R7: A cycle with `start` high clears pattern progress and returns the prefix machine to `G_WAIT0`. Any bit presented in that cycle is discarded, and `hit` is 0 in that cycle.
- R8: `qual_mode` is captured only on reset and start cycles. Changing it at any other time has no effect until the next start.
- R9: `hit` is 0 while `rst` is high and after reset until a pattern completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a new stream and captures the mode |
| bit_vld | input | 1 | `bit_in` holds an accepted bit this cycle |
| bit_in | input | 1 | Serial data bit |
| qual_mode | input | 1 | 0 selects free mode, 1 selects qualified mode |
| hit | output | 1 | One-cycle flag on the final bit of an occurrence |

## Verification
The checker watches, on every cycle:
- that a hit only appears on an accepted bit of value 1, after at least seven earlier accepted bits since the last start;
- that hits are never adjacent;
- that a start is never followed by an immediate hit;
- that a stream locked out by a bad prefix stays silent.

Some behaviours can only be shown by the bench's scenarios, which compare against the reference model on every clock:
- the exact positions of overlapping hits;
- the role of the second prefix zero as the first pattern bit;
- the discarding of a bit presented with start;
- the insensitivity to mode changes in the middle of a stream.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int PAT_LEN = 8;
    localparam logic [PAT_LEN-1:0] PAT_BITS = 8'b0110_1001;
    localparam int PROG_W = $clog2(PAT_LEN);

    typedef enum logic [PROG_W-1:0] {
        M0, M1, M2, M3, M4, M5, M6, M7
    } prog_e;

    typedef enum logic [1:0] {
        G_WAIT0, G_WAIT1, G_PASS, G_LOCK
    } gate_e;
endpackage

// File: rtl/pw_progress_fsm.sv
module pw_progress_fsm
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    input  logic din,
    output logic raw_hit
);
    prog_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst || clr) state_q <= M0;
        else if (adv)   state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M0: state_d = din ? M0 : M1;
            M1: state_d = din ? M2 : M1;
            M2: state_d = din ? M3 : M1;
            M3: state_d = din ? M0 : M4;
            M4: state_d = din ? M5 : M1;
            M5: state_d = din ? M3 : M6;
            M6: state_d = din ? M2 : M7;
            M7: state_d = din ? M2 : M1;
            default: state_d = M0;
        endcase
    end

    always_comb begin
        raw_hit = (state_q == M7) && din;
    end
endmodule

// File: rtl/pw_prefix_fsm.sv
module pw_prefix_fsm
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    input  logic din,
    output logic pass
);
    gate_e gate_q, gate_d;

    always_ff @(posedge clk) begin
        if (rst || clr) gate_q <= G_WAIT0;
        else if (adv)   gate_q <= gate_d;
    end

    always_comb begin
        gate_d = gate_q;
        unique case (gate_q)
            G_WAIT0: gate_d = din ? G_LOCK : G_WAIT1;
            G_WAIT1: gate_d = din ? G_LOCK : G_PASS;
            G_PASS:  gate_d = G_PASS;
            G_LOCK:  gate_d = G_LOCK;
            default: gate_d = G_WAIT0;
        endcase
    end

    always_comb begin
        pass = (gate_q == G_PASS);
    end
endmodule

// File: rtl/pw_mode_latch.sv
module pw_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic mode_in,
    output logic mode_q
);
    always_ff @(posedge clk) begin
        if (rst || clr) mode_q <= mode_in;
    end
endmodule

// File: rtl/pw_detector.sv
module pw_detector
    import pw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic qual_mode,
    output logic hit
);
    logic adv;
    logic raw_hit;
    logic pass;
    logic mode_q;

    always_comb begin
        adv = bit_vld && !start;
    end

    pw_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .mode_in (qual_mode),
        .mode_q  (mode_q)
    );

    pw_progress_fsm u_prog (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .adv     (adv),
        .din     (bit_in),
        .raw_hit (raw_hit)
    );

    pw_prefix_fsm u_gate (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .adv  (adv),
        .din  (bit_in),
        .pass (pass)
    );

    always_comb begin
        hit = !rst && adv && raw_hit && (!mode_q || pass);
    end
endmodule

// File: rtl/pw_detector_chk.sv
module pw_detector_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic bit_vld,
    input logic bit_in,
    input logic qual_mode,
    input logic hit
);
    logic [3:0] seen_c;
    logic       mode_c;
    logic       lock_c;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            seen_c <= 4'd0;
            mode_c <= qual_mode;
            lock_c <= 1'b0;
        end else if (bit_vld) begin
            if (seen_c < 4'd8) seen_c <= seen_c + 4'd1;
            if (mode_c && seen_c < 4'd2 && bit_in) lock_c <= 1'b1;
        end
    end

    // R4
    hit_on_accept_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (bit_vld && !start));

    // R1
    hit_full_window_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (bit_in && seen_c >= 4'd7));

    // R3
    hit_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> !hit);

    // R5
    qual_lock_chk: assert property (@(posedge clk) disable iff (rst)
        lock_c |-> !hit);

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !hit);
endmodule

bind pw_detector pw_detector_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .qual_mode (qual_mode),
    .hit       (hit)
);

// File: tb/pw_detector_tb.sv
module pw_detector_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic qual_mode = 1'b0;
    logic hit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    bit hist[$];
    int nvalid = 0;
    bit first0 = 1'b0;
    bit first1 = 1'b0;
    bit mode_m = 1'b0;

    always #5 clk = ~clk;

    pw_detector u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .bit_vld   (bit_vld),
        .bit_in    (bit_in),
        .qual_mode (qual_mode),
        .hit       (hit)
    );

    function automatic bit model_expect(bit r, bit s, bit v, bit b);
        int w;
        bit ok;
        if (r || s || !v) return 1'b0;
        if (hist.size() < 7) return 1'b0;
        w = 0;
        for (int i = hist.size() - 7; i < hist.size(); i++) w = (w << 1) | int'(hist[i]);
        w = (w << 1) | int'(b);
        ok = !mode_m || (nvalid >= 2 && !first0 && !first1);
        return (w == 8'b0110_1001) && ok;
    endfunction

    task automatic step(input string tag, input bit r, input bit s,
                        input bit v, input bit b, input bit m);
        bit exp;
        @(negedge clk);
        rst = r; start = s; bit_vld = v; bit_in = b; qual_mode = m;
        #1;
        exp = model_expect(r, s, v, b);
        checks++;
        if (hit !== exp) begin
            fails++;
            $display("FAIL %s: hit actual=%b expected=%b", tag, hit, exp);
        end
        if (r || s) begin
            hist.delete(); nvalid = 0; first0 = 0; first1 = 0; mode_m = m;
        end else if (v) begin
            if (nvalid == 0) first0 = b;
            if (nvalid == 1) first1 = b;
            nvalid++;
            hist.push_back(b);
            if (hist.size() > 8) void'(hist.pop_front());
        end
    endtask

    task automatic feed(input string tag, input string bits, input bit m);
        for (int i = 0; i < bits.len(); i++)
            step(tag, 1'b0, 1'b0, 1'b1, bits[i] == "1", m);
    endtask

    task automatic restart(input string tag, input bit m);
        step(tag, 1'b0, 1'b1, 1'b0, 1'b0, m);
    endtask

    initial begin
        int lfsr;
        // R9: reset state
        for (int i = 0; i < 3; i++) step("R9", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) step("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

        // R2: overlapping hits in free mode
        feed("R2", "01101001101001", 1'b0);

        // R4: idle cycles with bit_in toggling, inside a pattern
        restart("R4", 1'b0);
        feed("R4", "0110", 1'b0);
        for (int i = 0; i < 4; i++) step("R4", 1'b0, 1'b0, 1'b0, i[0], 1'b0);
        feed("R4", "100", 1'b0);
        step("R4", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        feed("R4", "1", 1'b0);

        // R3: back-to-back overlapping occurrences
        restart("R3", 1'b0);
        feed("R3", "01101001101001101001101001", 1'b0);

        // R1: pseudo-random stream in free mode
        restart("R1", 1'b0);
        lfsr = 32'h1ACE;
        for (int i = 0; i < 600; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            step("R1", 1'b0, 1'b0, (lfsr & 8) != 0 || (lfsr & 16) != 0, lfsr[0], 1'b0);
        end

        // R6: qualified streams with a good prefix
        restart("R6", 1'b1);
        feed("R6", "0001101001", 1'b1);
        restart("R6", 1'b1);
        feed("R6", "001101001", 1'b1);
        restart("R6", 1'b1);
        feed("R6", "00101101001101001", 1'b1);

        // R5: qualified streams with a bad prefix
        restart("R5", 1'b1);
        feed("R5", "1001101001", 1'b1);
        restart("R5", 1'b1);
        feed("R5", "0101101001101001", 1'b1);

        // R8: mode change mid-stream is ignored
        restart("R8", 1'b1);
        feed("R8", "10", 1'b1);
        feed("R8", "01101001", 1'b0);
        restart("R8", 1'b0);
        feed("R8", "1", 1'b0);
        feed("R8", "01101001", 1'b1);

        // R7: start discards a bit that would complete a pattern
        restart("R7", 1'b0);
        feed("R7", "0110100", 1'b0);
        step("R7", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        feed("R7", "1", 1'b0);
        feed("R7", "01101001", 1'b0);
        restart("R7", 1'b1);
        feed("R7", "1", 1'b1);
        restart("R7", 1'b1);
        feed("R7", "001101001", 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule